// File: doc/BRIEF.md
# Dual Gate Generator Register Slave

This block is the register slave of a two-channel gate generator. It sits behind a simplified synchronous bus carrying a 24-bit address, a 6-bit address-modifier code, 16-bit write data and separate read and write strobes. It owns the gate-width registers that the counting logic compares against. It also issues one-cycle trigger pulses to each channel, reports channel status, serves fixed identification words and flags illegal writes as bus errors.

Each channel's width is eight BCD digits held as 32 bits, reached as two 16-bit words. A channel can be under front-panel (local) control. While it is, width writes from the bus are still taken, but width reads return the local register supplied by the panel logic. Accesses are decoded against a 256-byte page whose upper address bits come from a base-address input. Every response (acknowledge, bus error, read data, trigger) is registered and appears one clock after the strobe.

Top module: `gate_reg_slave`

## Requirements
- R1: An access (rd_i or wr_i high; on both, it is a write) is taken only when amod_i is 0x3D, 0x39, 0x0D or 0x09, addr_i[23:8] equals base_i and addr_i[0] is 0. A taken access that is not a bus error raises ack_o for exactly the next cycle. An access that is not taken gives neither ack_o nor berr_o, and changes no state.
- R2: Byte offset 0x02 holds bits 31:16 and offset 0x04 holds bits 15:0 of the channel 0 width. Offsets 0x06 and 0x08 do the same for channel 1. A write updates width_o[ch] in the cycle of its acknowledge. A read returns the stored half.
- R3: While local_mode_i[ch] is 1, width reads of that channel return the matching half of local_width_i[ch]. Writes still update width_o[ch]. The other channel is unaffected.
- R4: A read at offset 0x00 returns bit 15 = OR over both channels of (local mode or gate open), bit 14/13 = local_mode_i[1]/[0], and bit 12/11 = gate_open_i[1]/[0]. All other bits are 0.
- R5: A write at offset 0x00 with bit 10 set pulses trig_o[1], and with bit 9 set pulses trig_o[0]. Each pulse lasts one cycle and coincides with ack_o. Bits 8:0 are ignored.
- R6: A write at offset 0x00 with any of bits 15:11 set gives berr_o for one cycle instead of ack_o and fires no trigger. It sets berr_led_o, which stays 1 until reset.
- R7: Offset 0xFA reads 0xFAF5. Offset 0xFC reads 0x080A (manufacturer 000010b in bits 15:10, type 0000001010b in bits 9:0). Offset 0xFE reads {VERSION[3:0], SERIAL[11:0]}. Writes to these offsets are acknowledged and change nothing.
- R8: Offsets 0x0A to 0xF8 are acknowledged, read as 0, and ignore writes.
- R9: After reset, width_o, rdata_o, ack_o, berr_o, berr_led_o and trig_o are all 0.
- R10: rdata_o is 0 in every cycle except the one following an acknowledged read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | Byte address |
| amod_i | input | 6 | Address-modifier code |
| base_i | input | 16 | Page base, compared with addr_i[23:8] |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| local_mode_i | input | 2 | Per-channel local (panel) control active |
| gate_open_i | input | 2 | Per-channel gate currently open |
| local_width_i | input | 2x32 | Per-channel local width register |
| rdata_o | output | 16 | Read data |
| ack_o | output | 1 | Access acknowledge |
| berr_o | output | 1 | Bus error |
| berr_led_o | output | 1 | Sticky bus-error indicator |
| width_o | output | 2x32 | Per-channel bus-written width |
| trig_o | output | 2 | Per-channel trigger pulse |

## Verification
Every result of an access is due exactly one clock after the edge that samples the strobe. This covers ack_o, berr_o, rdata_o, trig_o, the width_o update and the berr_led_o set. The bench therefore drives each access on a falling edge and holds it through one rising edge. It samples all outputs on the next falling edge, in the same place for every vector. The sticky indicator and the idle-zero read data are checked again on later falling edges, with no access in between. The local-mode and status reads sample inputs that are held steady across the sampling edge.

// File: rtl/gg_pkg.sv
package gg_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CSR,
    SEL_WHI,
    SEL_WLO,
    SEL_IDFIX,
    SEL_IDMFR,
    SEL_IDVER
  } reg_sel_e;

  localparam logic [15:0] ID_FIXED = 16'hFAF5;
  localparam logic [5:0]  MFR_NUM  = 6'b000010;
  localparam logic [9:0]  MOD_TYPE = 10'b0000001010;

  function automatic logic amod_ok(input logic [5:0] am);
    case (am)
      6'h3D, 6'h39, 6'h0D, 6'h09: amod_ok = 1'b1;
      default:                    amod_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gg_decode.sv
module gg_decode
  import gg_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 8,
  parameter int NCH    = 2,
  parameter int CH_W   = 1
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [5:0]               amod_i,
  input  logic [ADDR_W-PAGE_W-1:0] base_i,
  input  logic                     rd_i,
  input  logic                     wr_i,
  output logic                     hit_o,
  output reg_sel_e                 sel_o,
  output logic [CH_W-1:0]          ch_o
);
  localparam int IDX_W = PAGE_W - 1;
  localparam logic [IDX_W-1:0] IDX_TOP  = '1;
  localparam logic [IDX_W-1:0] IDX_WEND = IDX_W'(2 * NCH);

  logic [IDX_W-1:0] idx, widx;

  assign idx  = addr_i[PAGE_W-1:1];
  assign widx = idx - IDX_W'(1);

  assign hit_o = (rd_i | wr_i) && amod_ok(amod_i)
              && (addr_i[ADDR_W-1:PAGE_W] == base_i) && !addr_i[0];

  // width words: hi then lo per channel, starting at word 1
  always_comb begin
    sel_o = SEL_NONE;
    ch_o  = CH_W'(widx >> 1);
    if (idx == '0)                   sel_o = SEL_CSR;
    else if (idx <= IDX_WEND)        sel_o = widx[0] ? SEL_WLO : SEL_WHI;
    else if (idx == IDX_TOP)         sel_o = SEL_IDVER;
    else if (idx == IDX_TOP - IDX_W'(1)) sel_o = SEL_IDMFR;
    else if (idx == IDX_TOP - IDX_W'(2)) sel_o = SEL_IDFIX;
  end

endmodule

// File: rtl/gg_width_bank.sv
module gg_width_bank #(
  parameter int NCH    = 2,
  parameter int CH_W   = 1,
  parameter int DATA_W = 16,
  parameter int WW     = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic                      hi_i,
  input  logic [CH_W-1:0]           ch_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [NCH-1:0][WW-1:0]    width_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_c;
    assign sel_c = we_i && (ch_i == CH_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        width_o[c] <= '0;
      end else if (sel_c) begin
        if (hi_i) width_o[c][WW-1:DATA_W] <= wdata_i;
        else      width_o[c][DATA_W-1:0]  <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/gg_csr.sv
module gg_csr #(
  parameter int NCH    = 2,
  parameter int DATA_W = 16,
  parameter int CTL_W  = 1 + 3 * NCH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [NCH-1:0]    local_i,
  input  logic [NCH-1:0]    gate_i,
  output logic [DATA_W-1:0] status_o,
  output logic              bad_o,
  output logic [NCH-1:0]    trig_o,
  output logic              berr_o,
  output logic              berr_led_o
);
  localparam int RO_W = 1 + 2 * NCH;

  logic err_any;

  assign err_any  = |(local_i | gate_i);
  assign status_o = {err_any, local_i, gate_i, {(DATA_W - RO_W){1'b0}}};
  assign bad_o    = |ctl_i[CTL_W-1 -: RO_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o     <= '0;
      berr_o     <= 1'b0;
      berr_led_o <= 1'b0;
    end else begin
      trig_o     <= (wr_stb_i && !bad_o) ? ctl_i[NCH-1:0] : '0;
      berr_o     <= wr_stb_i && bad_o;
      berr_led_o <= berr_led_o | (wr_stb_i && bad_o);
    end
  end

endmodule

// File: rtl/gate_reg_slave.sv
module gate_reg_slave
  import gg_pkg::*;
#(
  parameter int          ADDR_W  = 24,
  parameter int          PAGE_W  = 8,
  parameter int          DATA_W  = 16,
  parameter int          NCH     = 2,
  parameter logic [3:0]  VERSION = 4'h3,
  parameter logic [11:0] SERIAL  = 12'h05A,
  localparam int BASE_W = ADDR_W - PAGE_W,
  localparam int WW     = 2 * DATA_W,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [5:0]             amod_i,
  input  logic [BASE_W-1:0]      base_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [NCH-1:0]         local_mode_i,
  input  logic [NCH-1:0]         gate_open_i,
  input  logic [NCH-1:0][WW-1:0] local_width_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   ack_o,
  output logic                   berr_o,
  output logic                   berr_led_o,
  output logic [NCH-1:0][WW-1:0] width_o,
  output logic [NCH-1:0]         trig_o
);
  localparam int CTL_W = 1 + 3 * NCH;

  logic              hit;
  reg_sel_e          sel;
  logic [CH_W-1:0]   ch;
  logic              csr_wr, csr_bad, width_we;
  logic [DATA_W-1:0] status, rd_mux;
  logic [WW-1:0]     rd_src;

  gg_decode #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NCH(NCH), .CH_W(CH_W)
  ) u_dec (
    .addr_i(addr_i), .amod_i(amod_i), .base_i(base_i),
    .rd_i(rd_i), .wr_i(wr_i),
    .hit_o(hit), .sel_o(sel), .ch_o(ch)
  );

  assign width_we = hit && wr_i && (sel == SEL_WHI || sel == SEL_WLO);
  assign csr_wr   = hit && wr_i && (sel == SEL_CSR);

  gg_width_bank #(
    .NCH(NCH), .CH_W(CH_W), .DATA_W(DATA_W), .WW(WW)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(width_we), .hi_i(sel == SEL_WHI), .ch_i(ch),
    .wdata_i(wdata_i), .width_o(width_o)
  );

  gg_csr #(
    .NCH(NCH), .DATA_W(DATA_W), .CTL_W(CTL_W)
  ) u_csr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_stb_i(csr_wr), .ctl_i(wdata_i[DATA_W-1 -: CTL_W]),
    .local_i(local_mode_i), .gate_i(gate_open_i),
    .status_o(status), .bad_o(csr_bad),
    .trig_o(trig_o), .berr_o(berr_o), .berr_led_o(berr_led_o)
  );

  // local mode redirects width reads to the panel register
  assign rd_src = local_mode_i[ch] ? local_width_i[ch] : width_o[ch];

  always_comb begin
    case (sel)
      SEL_CSR:   rd_mux = status;
      SEL_WHI:   rd_mux = rd_src[WW-1:DATA_W];
      SEL_WLO:   rd_mux = rd_src[DATA_W-1:0];
      SEL_IDFIX: rd_mux = ID_FIXED;
      SEL_IDMFR: rd_mux = {MFR_NUM, MOD_TYPE};
      SEL_IDVER: rd_mux = {VERSION, SERIAL};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= hit && !(csr_wr && csr_bad);
      rdata_o <= (hit && !wr_i) ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/gg_chk.sv
module gg_chk
  import gg_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 16,
  parameter int NCH    = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [5:0]                 amod_i,
  input logic [ADDR_W-PAGE_W-1:0]   base_i,
  input logic                       rd_i,
  input logic                       wr_i,
  input logic [DATA_W-1:0]          wdata_i,
  input logic [DATA_W-1:0]          rdata_o,
  input logic                       ack_o,
  input logic                       berr_o,
  input logic                       berr_led_o,
  input logic [NCH-1:0]             trig_o
);
  logic chk_hit, chk_csr_wr, chk_bad;

  assign chk_hit = (rd_i | wr_i) && amod_ok(amod_i)
                && (addr_i[ADDR_W-1:PAGE_W] == base_i) && !addr_i[0];
  assign chk_csr_wr = chk_hit && wr_i && (addr_i[PAGE_W-1:1] == '0);
  assign chk_bad    = |wdata_i[DATA_W-1 -: (1 + 2 * NCH)];

  // R1
  ack_berr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && berr_o));

  // R1
  unselected_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && !chk_hit) |=> (!ack_o && !berr_o));

  // R5
  trig_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trig_o) |-> $past(chk_csr_wr && !chk_bad));

  // R5
  trig_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|trig_o) |-> ack_o);

  // R6
  berr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> $past(chk_csr_wr && chk_bad));

  // R6
  berr_sets_led_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> berr_led_o);

  // R6
  led_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_led_o |=> berr_led_o);

  // R10
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> (rdata_o == '0));

endmodule

bind gate_reg_slave gg_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .NCH(NCH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .amod_i(amod_i),
  .base_i(base_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .ack_o(ack_o), .berr_o(berr_o),
  .berr_led_o(berr_led_o), .trig_o(trig_o)
);

// File: tb/tb_gate_reg_slave.sv
`timescale 1ns/100ps
module tb_gate_reg_slave;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [23:0]       addr_i = '0;
  logic [5:0]        amod_i = '0;
  logic [15:0]       base_i = 16'h1234;
  logic              rd_i = 1'b0, wr_i = 1'b0;
  logic [15:0]       wdata_i = '0;
  logic [1:0]        local_mode_i = '0, gate_open_i = '0;
  logic [1:0][31:0]  local_width_i = '0;
  logic [15:0]       rdata_o;
  logic              ack_o, berr_o, berr_led_o;
  logic [1:0][31:0]  width_o;
  logic [1:0]        trig_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [15:0] s_rdata;
  logic        s_ack, s_berr;
  logic [1:0]  s_trig;

  always #2.5 clk_i = ~clk_i;

  gate_reg_slave #(.VERSION(4'h3), .SERIAL(12'h05A)) dut (.*);

  // {wr, offset, wdata, exp_rdata, exp_ack, exp_berr, exp_trig}
  localparam int NV = 21;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 8'h02, 16'h0000, 16'h0000, 1'b1, 1'b0, 2'b00},  // R2
    {1'b1, 8'h04, 16'h1230, 16'h0000, 1'b1, 1'b0, 2'b00},  // R2
    {1'b0, 8'h04, 16'h0000, 16'h1230, 1'b1, 1'b0, 2'b00},  // R2
    {1'b0, 8'h02, 16'h0000, 16'h0000, 1'b1, 1'b0, 2'b00},  // R2
    {1'b1, 8'h06, 16'h9999, 16'h0000, 1'b1, 1'b0, 2'b00},  // R2
    {1'b1, 8'h08, 16'h9998, 16'h0000, 1'b1, 1'b0, 2'b00},  // R2
    {1'b0, 8'h06, 16'h0000, 16'h9999, 1'b1, 1'b0, 2'b00},  // R2
    {1'b0, 8'h08, 16'h0000, 16'h9998, 1'b1, 1'b0, 2'b00},  // R2
    {1'b0, 8'hFC, 16'h0000, 16'h080A, 1'b1, 1'b0, 2'b00},  // R7
    {1'b0, 8'hFA, 16'h0000, 16'hFAF5, 1'b1, 1'b0, 2'b00},  // R7
    {1'b0, 8'hFE, 16'h0000, 16'h305A, 1'b1, 1'b0, 2'b00},  // R7
    {1'b1, 8'hFC, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 2'b00},  // R7
    {1'b0, 8'hFC, 16'h0000, 16'h080A, 1'b1, 1'b0, 2'b00},  // R7
    {1'b0, 8'h00, 16'h0000, 16'h0000, 1'b1, 1'b0, 2'b00},  // R4
    {1'b1, 8'h00, 16'h0400, 16'h0000, 1'b1, 1'b0, 2'b10},  // R5
    {1'b1, 8'h00, 16'h0200, 16'h0000, 1'b1, 1'b0, 2'b01},  // R5
    {1'b1, 8'h00, 16'h06FF, 16'h0000, 1'b1, 1'b0, 2'b11},  // R5
    {1'b0, 8'h40, 16'h0000, 16'h0000, 1'b1, 1'b0, 2'b00},  // R8
    {1'b1, 8'h40, 16'hABCD, 16'h0000, 1'b1, 1'b0, 2'b00},  // R8
    {1'b0, 8'h40, 16'h0000, 16'h0000, 1'b1, 1'b0, 2'b00},  // R8
    {1'b1, 8'h00, 16'h0E00, 16'h0000, 1'b0, 1'b1, 2'b00}   // R6
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // drive on falling edge, hold through one rising edge, sample next falling edge
  task automatic access(input logic wr, input logic [23:0] addr, input logic [15:0] wd,
                        input logic [5:0] am);
    @(negedge clk_i);
    addr_i = addr; amod_i = am; wdata_i = wd; wr_i = wr; rd_i = !wr;
    @(negedge clk_i);
    s_rdata = rdata_o; s_ack = ack_o; s_berr = berr_o; s_trig = trig_o;
    rd_i = 1'b0; wr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 outputs in reset", {rdata_o, ack_o, berr_o, berr_led_o, trig_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 width after reset", width_o, '0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][44], {16'h1234, VEC[i][43:36]}, VEC[i][35:20], 6'h39);
      check($sformatf("R2/R4/R5/R6/R7/R8 vector %0d", i),
            {s_rdata, s_ack, s_berr, s_trig}, {VEC[i][19:4], VEC[i][3:0]});
    end

    check("R2 width ch0", width_o[0], 32'h0000_1230);
    check("R2 width ch1", width_o[1], 32'h9999_9998);
    check("R6 sticky led", berr_led_o, 1'b1);
    repeat (4) @(negedge clk_i);
    check("R6 led held, pulse gone", {berr_led_o, berr_o}, 2'b10);
    check("R10 idle rdata zero", rdata_o, '0);

    // R3 local mode redirect
    local_mode_i = 2'b01;
    local_width_i[0] = 32'h8765_4321;
    local_width_i[1] = 32'hDEAD_BEEF;
    access(1'b0, 24'h123402, '0, 6'h39);
    check("R3 local hi", s_rdata, 16'h8765);
    access(1'b0, 24'h123404, '0, 6'h39);
    check("R3 local lo", s_rdata, 16'h4321);
    access(1'b0, 24'h123406, '0, 6'h39);
    check("R3 other channel unaffected", s_rdata, 16'h9999);
    access(1'b1, 24'h123404, 16'h5555, 6'h39);
    check("R3 write in local accepted", {s_ack, width_o[0]}, {1'b1, 32'h0000_5555});
    access(1'b0, 24'h123404, '0, 6'h39);
    check("R3 read still local", s_rdata, 16'h4321);

    // R4 status word
    gate_open_i = 2'b10;
    access(1'b0, 24'h123400, '0, 6'h39);
    check("R4 status", s_rdata, 16'hB000);
    local_mode_i = 2'b00; gate_open_i = 2'b01;
    access(1'b0, 24'h123400, '0, 6'h39);
    check("R4 status gate0", s_rdata, 16'h8800);
    gate_open_i = 2'b00;

    // R1 decode
    access(1'b1, 24'h123402, 16'hFFFF, 6'h3E);
    check("R1 bad amod ignored", {s_ack, s_berr, width_o[0]}, {2'b00, 32'h0000_5555});
    access(1'b1, 24'h123502, 16'hFFFF, 6'h39);
    check("R1 bad base ignored", {s_ack, s_berr, width_o[0]}, {2'b00, 32'h0000_5555});
    access(1'b0, 24'h123403, '0, 6'h39);
    check("R1 odd address", {s_ack, s_rdata}, '0);
    access(1'b1, 24'h123400, 16'hF800, 6'h3E);
    check("R1 unselected csr no berr", {s_ack, s_berr, s_trig}, '0);
    access(1'b0, 24'h1234FC, '0, 6'h3D);
    check("R1 amod 3D", {s_ack, s_rdata}, {1'b1, 16'h080A});
    access(1'b0, 24'h1234FC, '0, 6'h0D);
    check("R1 amod 0D", {s_ack, s_rdata}, {1'b1, 16'h080A});
    access(1'b0, 24'h1234FC, '0, 6'h09);
    check("R1 amod 09", {s_ack, s_rdata}, {1'b1, 16'h080A});
    access(1'b1, 24'h12340A, 16'h7777, 6'h39);
    check("R8 offset 0A write ignored", {s_ack, width_o}, {1'b1, 32'h9999_9998, 32'h0000_5555});

    // R9 second reset clears sticky and widths
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R9 reset clears", {berr_led_o, width_o}, '0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule